// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Sequencer

This block runs a receiver that spends most of its time powered down. A counter of slow wake ticks brings the receiver out of sleep at a programmable interval. The block then powers up its parts in a fixed order: first the reference oscillator, then the synthesizer, then the receive chain. After that it waits for the signal-strength measurement to settle.

From there it takes one of two paths. With the strength gate off, it goes straight into a bounded search for a preamble. With the gate on, it takes one strength sample. That sample must clear a fixed floor and must also reach a margin above a background level, which is learned from earlier idle wake-ups. If either test fails, the block powers everything down at once and folds the sample into the background level.

Once a preamble is seen, the receiver stays on and hunts for a frame delimiter, again within a bounded window. Only a packet that completes with a good check raises the host interrupt. A search that times out, or a packet that fails its check, sends the block back to sleep quietly. Demodulation, the analog measurement and packet storage sit outside the block. They report to it through single-cycle strobes.

Top module: `wor_rx_gate`

## Requirements
- R1: After reset the block is in the sleep state (code 0). All three power enables and the interrupt are low, and the background level reads 0.
- R2: In sleep, the block counts wake ticks. On the tick that brings the count to `cfg_wake_period` it leaves sleep, and the count then starts again from zero. A period of 0 behaves like a period of 1. The block never leaves sleep in a cycle without a tick.
- R3: The block steps through fixed states. Its state codes are:
  - 0: sleep
  - 1: oscillator start
  - 2: synthesizer start
  - 3: measurement settle
  - 4: strength sample
  - 5: preamble search
  - 6: delimiter search
  - 7: packet receive

  `ref_en` is high in every state except 0. `synth_en` is high in states 2 to 7. `rx_en` is high in states 3 to 7. State 1 moves on after `ref_ready`, and state 2 moves on after `synth_ready`.
- R4: The settle state lasts `cfg_settle`+1 cycles. After it, the block enters state 4 when `cfg_gate_en` is 1, and state 5 when `cfg_gate_en` is 0.
- R5: In state 4, a valid sample that is not strictly greater than `cfg_abs_thr` returns the block to sleep.
- R6: In state 4, a valid sample that is below the background level plus `cfg_rel_thr` returns the block to sleep. A sample that passes both this test and the R5 test enters state 5. Equal to the sum counts as passing.
- R7: The background level changes only when a sample is rejected. It then becomes avg + ((sample − avg) >>> `cfg_avg_shift`), using arithmetic (floor) shifting. A sample that passes leaves the level unchanged.
- R8: In state 5, `pre_det` moves the block to state 6. Without it, the block returns to sleep after `cfg_pre_win`+1 cycles in state 5.
- R9: In state 6, `delim_det` moves the block to state 7. Without it, the block returns to sleep after `cfg_delim_win`+1 cycles in state 6.
- R10: In state 7, `pkt_done` returns the block to sleep. When `pkt_crc_ok` is 1 at that strobe, `host_irq` is high for exactly the next cycle. When it is 0, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wake_tick | input | 1 | Slow timebase tick |
| ref_ready | input | 1 | Reference oscillator settled strobe |
| synth_ready | input | 1 | Synthesizer settled strobe |
| rssi_val | input | RW | Signal-strength sample |
| rssi_vld | input | 1 | Sample valid strobe |
| pre_det | input | 1 | Preamble found pulse |
| delim_det | input | 1 | Frame delimiter found pulse |
| pkt_done | input | 1 | Packet complete pulse |
| pkt_crc_ok | input | 1 | Packet check passed, qualifies pkt_done |
| cfg_wake_period | input | PW | Wake interval in ticks |
| cfg_gate_en | input | 1 | Enable strength gate |
| cfg_abs_thr | input | RW | Absolute strength floor |
| cfg_rel_thr | input | RW | Margin over background level |
| cfg_avg_shift | input | KW | Averaging shift |
| cfg_settle | input | CW | Strength settle time, cycles minus one |
| cfg_pre_win | input | CW | Preamble window, cycles minus one |
| cfg_delim_win | input | CW | Delimiter window, cycles minus one |
| ref_en | output | 1 | Reference oscillator enable |
| synth_en | output | 1 | Synthesizer enable |
| rx_en | output | 1 | Receive chain enable |
| host_irq | output | 1 | Valid packet interrupt pulse |
| state_o | output | 3 | Current state code |
| bg_avg_o | output | RW | Background strength level |

## Verification
The bench aims at the threshold edges:
- A sample exactly equal to the floor must be rejected. A design using >= there would wake the preamble search on noise.
- A sample exactly equal to background plus margin must pass. Using a strict compare there would lose weak but real signals.

The background average is driven both upward and downward. A logical shift in place of an arithmetic one would wrap the level to a huge value on the downward step. The level is also read after a passing sample, to catch an average that learns from real signals.

Both search windows are run to timeout and their lengths are counted. A packet with a failed check is sent to confirm that no interrupt leaks out. A zero wake period is also exercised, where an unguarded compare would never wake at all.

// File: rtl/wor_pkg.sv
package wor_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP  = 3'd0,
        ST_REF    = 3'd1,
        ST_SYN    = 3'd2,
        ST_SETTLE = 3'd3,
        ST_MEAS   = 3'd4,
        ST_PRE    = 3'd5,
        ST_DELIM  = 3'd6,
        ST_PKT    = 3'd7
    } wor_state_e;

    typedef struct packed {
        wor_state_e state;
        logic       irq;
    } wor_fsm_t;

endpackage

// File: rtl/wor_win_timer.sv
module wor_win_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wor_wake_timer.sv
module wor_wake_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [PW-1:0] period,
    output logic          fire
);
    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW:0]   eff_per;
    logic [PW:0]   nxt;

    always_comb begin
        eff_per = (period == '0) ? {{PW{1'b0}}, 1'b1} : {1'b0, period};
        nxt     = {1'b0, cnt_q} + 1'b1;
        fire    = en && tick && (nxt >= eff_per);
        cnt_d   = cnt_q;
        if (!en || fire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = nxt[PW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wor_bg_avg.sv
module wor_bg_avg #(
    parameter int RW = 8,
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [RW-1:0] sample,
    input  logic [KW-1:0] shift,
    output logic [RW-1:0] avg
);
    logic [RW-1:0] avg_d, avg_q;
    logic signed [RW:0] diff;
    logic signed [RW:0] step;
    logic signed [RW:0] sum;

    always_comb begin
        diff  = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
        step  = diff >>> shift;
        sum   = $signed({1'b0, avg_q}) + step;
        avg_d = upd ? sum[RW-1:0] : avg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) avg_q <= '0;
        else        avg_q <= avg_d;
    end

    assign avg = avg_q;
endmodule

// File: rtl/wor_rx_gate.sv
module wor_rx_gate
    import wor_pkg::*;
#(
    parameter int RW = 8,
    parameter int PW = 16,
    parameter int CW = 16,
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wake_tick,
    input  logic          ref_ready,
    input  logic          synth_ready,
    input  logic [RW-1:0] rssi_val,
    input  logic          rssi_vld,
    input  logic          pre_det,
    input  logic          delim_det,
    input  logic          pkt_done,
    input  logic          pkt_crc_ok,
    input  logic [PW-1:0] cfg_wake_period,
    input  logic          cfg_gate_en,
    input  logic [RW-1:0] cfg_abs_thr,
    input  logic [RW-1:0] cfg_rel_thr,
    input  logic [KW-1:0] cfg_avg_shift,
    input  logic [CW-1:0] cfg_settle,
    input  logic [CW-1:0] cfg_pre_win,
    input  logic [CW-1:0] cfg_delim_win,
    output logic          ref_en,
    output logic          synth_en,
    output logic          rx_en,
    output logic          host_irq,
    output logic [2:0]    state_o,
    output logic [RW-1:0] bg_avg_o
);
    localparam int SW = RW + 1;

    wor_fsm_t      fsm_d, fsm_q;
    logic          wake_fire;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          avg_upd;
    logic [SW-1:0] rel_lvl;
    logic          abs_ok;
    logic          rel_ok;

    wor_wake_timer #(.PW(PW)) wake_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (fsm_q.state == ST_SLEEP),
        .tick   (wake_tick),
        .period (cfg_wake_period),
        .fire   (wake_fire)
    );

    wor_win_timer #(.CW(CW)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    wor_bg_avg #(.RW(RW), .KW(KW)) avg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (avg_upd),
        .sample (rssi_val),
        .shift  (cfg_avg_shift),
        .avg    (bg_avg_o)
    );

    always_comb begin
        rel_lvl = {1'b0, bg_avg_o} + {1'b0, cfg_rel_thr};
        abs_ok  = (rssi_val > cfg_abs_thr);
        rel_ok  = ({1'b0, rssi_val} >= rel_lvl);
    end

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.irq = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        avg_upd   = 1'b0;
        case (fsm_q.state)
            ST_SLEEP: begin
                if (wake_fire) fsm_d.state = ST_REF;
            end
            ST_REF: begin
                if (ref_ready) fsm_d.state = ST_SYN;
            end
            ST_SYN: begin
                if (synth_ready) begin
                    fsm_d.state = ST_SETTLE;
                    tmr_load    = 1'b1;
                    tmr_val     = cfg_settle;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    if (cfg_gate_en) begin
                        fsm_d.state = ST_MEAS;
                    end else begin
                        fsm_d.state = ST_PRE;
                        tmr_load    = 1'b1;
                        tmr_val     = cfg_pre_win;
                    end
                end
            end
            ST_MEAS: begin
                if (rssi_vld) begin
                    if (abs_ok && rel_ok) begin
                        fsm_d.state = ST_PRE;
                        tmr_load    = 1'b1;
                        tmr_val     = cfg_pre_win;
                    end else begin
                        fsm_d.state = ST_SLEEP;
                        avg_upd     = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (pre_det) begin
                    fsm_d.state = ST_DELIM;
                    tmr_load    = 1'b1;
                    tmr_val     = cfg_delim_win;
                end else if (tmr_zero) begin
                    fsm_d.state = ST_SLEEP;
                end
            end
            ST_DELIM: begin
                if (delim_det) begin
                    fsm_d.state = ST_PKT;
                end else if (tmr_zero) begin
                    fsm_d.state = ST_SLEEP;
                end
            end
            ST_PKT: begin
                if (pkt_done) begin
                    fsm_d.state = ST_SLEEP;
                    fsm_d.irq   = pkt_crc_ok;
                end
            end
            default: fsm_d.state = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_SLEEP;
            fsm_q.irq   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o  = fsm_q.state;
    assign host_irq = fsm_q.irq;
    assign ref_en   = (fsm_q.state != ST_SLEEP);
    assign synth_en = (fsm_q.state != ST_SLEEP) && (fsm_q.state != ST_REF);
    assign rx_en    = (fsm_q.state >= ST_SETTLE);
endmodule

// File: rtl/wor_rx_gate_chk.sv
module wor_rx_gate_chk #(
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    state_o,
    input logic          ref_en,
    input logic          synth_en,
    input logic          rx_en,
    input logic          host_irq,
    input logic          wake_tick,
    input logic          pre_det,
    input logic          delim_det,
    input logic          pkt_done,
    input logic          pkt_crc_ok,
    input logic          rssi_vld,
    input logic          cfg_gate_en,
    input logic [RW-1:0] bg_avg_o
);
    p_sleep_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> (!ref_en && !synth_en && !rx_en));

    p_rx_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> (synth_en && ref_en));

    p_no_tick_no_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !wake_tick) |=> (state_o == 3'd0));

    p_gate_off_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && !cfg_gate_en) |=> (state_o != 3'd4));

    p_avg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 3'd4 || !rssi_vld) |=> $stable(bg_avg_o));

    p_pre_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && !pre_det) |=> (state_o != 3'd6));

    p_delim_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd6 && !delim_det) |=> (state_o != 3'd7));

    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq);

    p_irq_good_pkt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd7 && pkt_done && !pkt_crc_ok) |=> !host_irq);
endmodule

bind wor_rx_gate wor_rx_gate_chk #(.RW(RW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_o    (state_o),
    .ref_en     (ref_en),
    .synth_en   (synth_en),
    .rx_en      (rx_en),
    .host_irq   (host_irq),
    .wake_tick  (wake_tick),
    .pre_det    (pre_det),
    .delim_det  (delim_det),
    .pkt_done   (pkt_done),
    .pkt_crc_ok (pkt_crc_ok),
    .rssi_vld   (rssi_vld),
    .cfg_gate_en(cfg_gate_en),
    .bg_avg_o   (bg_avg_o)
);

// File: tb/wor_rx_gate_tb.sv
`timescale 1ns/1ps
module wor_rx_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wake_tick = 0, ref_ready = 0, synth_ready = 0;
    logic [7:0]  rssi_val = 0;
    logic        rssi_vld = 0, pre_det = 0, delim_det = 0, pkt_done = 0, pkt_crc_ok = 0;
    logic [15:0] cfg_wake_period = 16'd3;
    logic        cfg_gate_en = 0;
    logic [7:0]  cfg_abs_thr = 8'd100, cfg_rel_thr = 8'd0;
    logic [2:0]  cfg_avg_shift = 3'd2;
    logic [15:0] cfg_settle = 16'd2, cfg_pre_win = 16'd4, cfg_delim_win = 16'd4;
    logic        ref_en, synth_en, rx_en, host_irq;
    logic [2:0]  state_o;
    logic [7:0]  bg_avg_o;

    int total = 0, bad = 0, irq_cnt = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wor_rx_gate dut_i (
        .clk(clk), .rst_n(rst_n), .wake_tick(wake_tick), .ref_ready(ref_ready),
        .synth_ready(synth_ready), .rssi_val(rssi_val), .rssi_vld(rssi_vld),
        .pre_det(pre_det), .delim_det(delim_det), .pkt_done(pkt_done),
        .pkt_crc_ok(pkt_crc_ok), .cfg_wake_period(cfg_wake_period),
        .cfg_gate_en(cfg_gate_en), .cfg_abs_thr(cfg_abs_thr), .cfg_rel_thr(cfg_rel_thr),
        .cfg_avg_shift(cfg_avg_shift), .cfg_settle(cfg_settle), .cfg_pre_win(cfg_pre_win),
        .cfg_delim_win(cfg_delim_win), .ref_en(ref_en), .synth_en(synth_en),
        .rx_en(rx_en), .host_irq(host_irq), .state_o(state_o), .bg_avg_o(bg_avg_o)
    );

    // behavioural reference model
    int m_st = 0, m_wc = 0, m_t = 0, m_avg = 0, m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_wc = 0; m_t = 0; m_avg = 0; m_irq = 0;
        end else begin
            int per;
            int nt;
            int d;
            nt = m_t;
            m_irq = 0;
            per = (cfg_wake_period == 0) ? 1 : int'(cfg_wake_period);
            if (m_t > 0) nt = m_t - 1;
            case (m_st)
                0: if (wake_tick) begin
                       m_wc = m_wc + 1;
                       if (m_wc >= per) begin m_st = 1; m_wc = 0; end
                   end
                1: if (ref_ready) m_st = 2;
                2: if (synth_ready) begin m_st = 3; nt = int'(cfg_settle); end
                3: if (m_t == 0) begin
                       if (cfg_gate_en) m_st = 4;
                       else begin m_st = 5; nt = int'(cfg_pre_win); end
                   end
                4: if (rssi_vld) begin
                       if ((int'(rssi_val) > int'(cfg_abs_thr)) &&
                           (int'(rssi_val) >= m_avg + int'(cfg_rel_thr))) begin
                           m_st = 5; nt = int'(cfg_pre_win);
                       end else begin
                           m_st = 0;
                           d = int'(rssi_val) - m_avg;
                           m_avg = m_avg + (d >>> cfg_avg_shift);
                       end
                   end
                5: if (pre_det) begin m_st = 6; nt = int'(cfg_delim_win); end
                   else if (m_t == 0) m_st = 0;
                6: if (delim_det) m_st = 7;
                   else if (m_t == 0) m_st = 0;
                default: if (pkt_done) begin m_st = 0; m_irq = pkt_crc_ok ? 1 : 0; end
            endcase
            m_t = nt;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (host_irq) irq_cnt++;
        if (rst_n && !done) begin
            check("R3 state vs model", int'(state_o), m_st);
            check("R3 ref_en", int'(ref_en), (m_st != 0) ? 1 : 0);
            check("R3 synth_en", int'(synth_en), (m_st >= 2) ? 1 : 0);
            check("R3 rx_en", int'(rx_en), (m_st >= 3) ? 1 : 0);
            check("R10 irq vs model", int'(host_irq), m_irq);
            check("R7 avg vs model", int'(bg_avg_o), m_avg);
        end
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_st(input int v);
        int n = 0;
        while (int'(state_o) != v && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic do_wake(input int ticks);
        for (int i = 0; i < ticks; i++) begin
            @(negedge clk) wake_tick = 1;
            @(negedge clk) wake_tick = 0;
        end
    endtask

    task automatic power_up();
        do_wake((cfg_wake_period == 0) ? 1 : int'(cfg_wake_period));
        check("R2 woke", int'(state_o), 1);
        @(negedge clk) ref_ready = 1;
        @(negedge clk) ref_ready = 0;
        check("R3 synth start", int'(state_o), 2);
        @(negedge clk) synth_ready = 1;
        @(negedge clk) synth_ready = 0;
        check("R3 settle entered", int'(state_o), 3);
    endtask

    task automatic sample(input int v);
        wait_st(4);
        rssi_val = 8'(v); rssi_vld = 1;
        @(negedge clk) rssi_vld = 0;
    endtask

    task automatic pulse_pre();
        wait_st(5);
        pre_det = 1;
        @(negedge clk) pre_det = 0;
    endtask

    task automatic pulse_delim();
        wait_st(6);
        delim_det = 1;
        @(negedge clk) delim_det = 0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset state", int'(state_o), 0);
        check("R1 reset enables", int'({ref_en, synth_en, rx_en}), 0);
        check("R1 reset irq", int'(host_irq), 0);
        check("R1 reset avg", int'(bg_avg_o), 0);
        rst_n = 1;
        @(negedge clk);

        // gate off, full good packet
        power_up();
        n = 0;
        while (state_o == 3'd3) begin n++; @(negedge clk); end
        check("R4 settle length", n, 3);
        check("R4 gate off skips sample", int'(state_o), 5);
        pulse_pre();
        check("R8 preamble found", int'(state_o), 6);
        pulse_delim();
        check("R9 delimiter found", int'(state_o), 7);
        pkt_done = 1; pkt_crc_ok = 1;
        @(negedge clk) begin pkt_done = 0; pkt_crc_ok = 0; end
        check("R10 irq raised", int'(host_irq), 1);
        check("R10 back to sleep", int'(state_o), 0);
        @(negedge clk);
        check("R10 irq one cycle", int'(host_irq), 0);

        // gate on, absolute rejects
        cfg_gate_en = 1;
        power_up();
        sample(40);
        check("R5 below floor sleeps", int'(state_o), 0);
        check("R7 avg up", int'(bg_avg_o), 10);
        power_up();
        sample(20);
        check("R7 avg 12", int'(bg_avg_o), 12);
        cfg_abs_thr = 8'd30;
        power_up();
        sample(30);
        check("R5 equal floor rejected", int'(state_o), 0);
        check("R7 avg 16", int'(bg_avg_o), 16);

        // relative threshold
        cfg_abs_thr = 8'd10; cfg_rel_thr = 8'd50;
        power_up();
        sample(30);
        check("R6 below relative sleeps", int'(state_o), 0);
        check("R7 avg 19", int'(bg_avg_o), 19);
        power_up();
        sample(69);
        check("R6 equal relative passes", int'(state_o), 5);
        check("R7 pass leaves avg", int'(bg_avg_o), 19);
        n = 0;
        while (state_o == 3'd5) begin n++; @(negedge clk); end
        check("R8 preamble window length", n, 5);
        check("R8 timeout sleeps", int'(state_o), 0);

        // delimiter timeout
        cfg_rel_thr = 8'd0;
        power_up();
        sample(200);
        pulse_pre();
        n = 0;
        while (state_o == 3'd6) begin n++; @(negedge clk); end
        check("R9 delimiter window length", n, 5);
        check("R9 timeout sleeps", int'(state_o), 0);

        // bad check packet
        power_up();
        sample(200);
        pulse_pre();
        pulse_delim();
        pkt_done = 1; pkt_crc_ok = 0;
        @(negedge clk) pkt_done = 0;
        check("R10 bad packet no irq", int'(host_irq), 0);
        check("R10 bad packet sleeps", int'(state_o), 0);
        check("R10 irq count", irq_cnt, 1);

        // downward average step
        cfg_abs_thr = 8'd250;
        power_up();
        sample(3);
        check("R7 avg down", int'(bg_avg_o), 15);

        // zero period wakes on a single tick
        cfg_wake_period = 16'd0; cfg_gate_en = 0;
        @(negedge clk);
        check("R2 idle without tick", int'(state_o), 0);
        power_up();
        wait_st(0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule